// File: doc/BRIEF.md
# Local-to-System Bus Master Bridge

The bridge carries single data reads and writes from a local data-memory port onto a wider, pipelined system bus, where it acts as a bus master. It holds one transaction at a time. A request that finds the bridge idle is accepted in the same cycle. The captured request then runs an address phase, followed by a data phase. Each phase is held until the slave answers with ready. A read's data phase simply lasts as long as the slave needs, and the selected word comes back to the requester one cycle after the slave delivers it.

While a transaction is in flight, any new request is refused in its own cycle with a reject pulse; nothing is queued. Local accesses elsewhere are unaffected, so the requester may serve other targets in parallel.

Writes are posted. Accepting a write is the end of the story for the requester, which never sees a response or an error for it. If the slave signals an error in either phase, the bridge abandons that transfer and does not retry it. It then spends exactly one cycle with the system bus fully released, lock included, before it takes new work. A failed read is reported to the requester as an error response with zeroed data. A lock request on an access keeps the system lock asserted from that access onward, until an unlocked access is accepted or an error occurs.

Top module: `lbus_bridge`

## Requirements
- R1: With the bridge idle, `loc_req` is answered by `loc_ack` in the same cycle. From the next cycle an address phase (`sys_avld`=1) presents the captured `loc_addr` and `loc_we`, even if the local inputs have changed since.
- R2: While a transaction or its release cycle is in progress, `loc_req` gives `loc_rej`=1 and `loc_ack`=0 in the same cycle. The refused request never reaches the system bus.
- R3: The address phase keeps `sys_avld`, `sys_addr` and `sys_write` steady until a cycle with `sys_rdy`=1 and `sys_err`=0. In the next cycle the data phase starts (`sys_dvld`=1, `sys_avld`=0).
- R4: A read's data phase lasts until `sys_rdy`=1. One cycle later, `loc_rsp_vld`=1 and `loc_rsp_err`=0 for exactly one cycle, with `loc_rdata` holding the word that was on the bus in the ready cycle.
- R5: During a write's data phase, `sys_wdata` carries `loc_wdata` copied into every lane. No write ever produces `loc_rsp_vld`, whether the write completes or fails.
- R6: A cycle with `sys_err`=1 in either phase ends the transfer. The next cycle is a single release cycle with `sys_avld`, `sys_dvld`, `sys_write` and `sys_lock` all 0, in which requests are rejected. The cycle after that accepts a new request.
- R7: A read that ends in a slave error gives `loc_rsp_vld`=1 with `loc_rsp_err`=1 and `loc_rdata`=0 in the release cycle.
- R8: `sys_lock` takes the value of `loc_lock` from an accepted request onward, starting with that request's address phase. It holds between transactions and is cleared by a slave error.
- R9: During synchronous active-low reset, and after it, the bridge is idle and `sys_avld`, `sys_dvld`, `sys_write`, `sys_lock` and `loc_rsp_vld` are 0.
- R10: The lane is selected by the address bits just above the local word's byte offset (bit 2 for 32-bit local words on a 64-bit bus; lane 0 is `sys_rdata[31:0]`). `sys_lane_en` is one-hot on that lane during both phases, and reads return that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_req | input | 1 | Local request strobe |
| loc_we | input | 1 | 1 = write, 0 = read |
| loc_lock | input | 1 | Request locked system access |
| loc_addr | input | AW | Byte address |
| loc_wdata | input | LDW | Write word |
| loc_ack | output | 1 | Request accepted this cycle |
| loc_rej | output | 1 | Request refused this cycle |
| loc_rsp_vld | output | 1 | Read response pulse |
| loc_rsp_err | output | 1 | Read ended in slave error |
| loc_rdata | output | LDW | Read word |
| sys_avld | output | 1 | Address phase active |
| sys_dvld | output | 1 | Data phase active |
| sys_addr | output | AW | System address |
| sys_write | output | 1 | Transfer is a write |
| sys_lock | output | 1 | Bus lock |
| sys_lane_en | output | SDW/LDW | One-hot lane of the transfer |
| sys_wdata | output | SDW | Write data, replicated over lanes |
| sys_rdata | input | SDW | Read data from slave |
| sys_rdy | input | 1 | Slave ready for current phase |
| sys_err | input | 1 | Slave error for current phase |

## Verification
A wrong state register shows up at once as a phase strobe that is missing, doubled or premature in the very cycle the bus expects it. It also shows up as an ack where a reject belongs. A lock flag that is left set after an error, or a release that lasts zero or two cycles, is visible within one or two cycles on `sys_lock` or on the acceptance of the next request. A wrong lane index or a mis-timed capture register gives a wrong `loc_rdata` in the response cycle. The sweep over waits, lanes, directions and error phases covers every one of these.

// File: rtl/lbus_bridge_pkg.sv
`timescale 1ns/1ps
package lbus_bridge_pkg;
   typedef enum logic [1:0] {
      BS_IDLE = 2'd0,
      BS_ADDR = 2'd1,
      BS_DATA = 2'd2,
      BS_REL  = 2'd3
   } brg_state_e;
endpackage

// File: rtl/lbus_bridge_seq.sv
`timescale 1ns/1ps
// Transaction sequencer: one slot, phase ordering, error release, lock flag.
module lbus_bridge_seq
   import lbus_bridge_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic loc_req,
   input  logic loc_lock,
   input  logic sys_rdy,
   input  logic sys_err,
   output logic accept,
   output logic reject,
   output logic ph_addr,
   output logic ph_data,
   output logic fin_ok,
   output logic fin_err,
   output logic lock_q
);
   brg_state_e st, st_nx;

   always_comb begin
      ph_addr = (st == BS_ADDR);
      ph_data = (st == BS_DATA);
      accept  = loc_req && (st == BS_IDLE);
      reject  = loc_req && (st != BS_IDLE);
      fin_err = (ph_addr || ph_data) && sys_err;
      fin_ok  = ph_data && sys_rdy && !sys_err;
      st_nx   = st;
      case (st)
         BS_IDLE: if (accept) st_nx = BS_ADDR;
         BS_ADDR: begin
            if (sys_err)      st_nx = BS_REL;
            else if (sys_rdy) st_nx = BS_DATA;
         end
         BS_DATA: begin
            if (sys_err)      st_nx = BS_REL;
            else if (sys_rdy) st_nx = BS_IDLE;
         end
         default: st_nx = BS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= BS_IDLE;
         lock_q <= 1'b0;
      end else begin
         st <= st_nx;
         if (accept)       lock_q <= loc_lock;
         else if (fin_err) lock_q <= 1'b0;
      end
   end
endmodule

// File: rtl/lbus_bridge_hold.sv
`timescale 1ns/1ps
// Request capture and read response registers.
module lbus_bridge_hold #(
   parameter int AW  = 32,
   parameter int LDW = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           accept,
   input  logic           loc_we,
   input  logic [AW-1:0]  loc_addr,
   input  logic [LDW-1:0] loc_wdata,
   input  logic           fin_ok,
   input  logic           fin_err,
   input  logic [LDW-1:0] rd_word,
   output logic [AW-1:0]  addr_q,
   output logic           we_q,
   output logic [LDW-1:0] wdata_q,
   output logic           rsp_vld,
   output logic           rsp_err,
   output logic [LDW-1:0] rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
         rsp_vld <= 1'b0;
         rsp_err <= 1'b0;
         rdata   <= '0;
      end else begin
         if (accept) begin
            addr_q  <= loc_addr;
            we_q    <= loc_we;
            wdata_q <= loc_wdata;
         end
         rsp_vld <= (fin_ok || fin_err) && !we_q;
         rsp_err <= fin_err && !we_q;
         if (!we_q && fin_err)     rdata <= '0;
         else if (!we_q && fin_ok) rdata <= rd_word;
      end
   end
endmodule

// File: rtl/lbus_bridge_lanes.sv
`timescale 1ns/1ps
// Lane mapping between the local word and the wider system bus.
module lbus_bridge_lanes #(
   parameter int LDW   = 32,
   parameter int SDW   = 64,
   parameter int LANES = SDW / LDW,
   parameter int LSW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LSW-1:0]   lane_sel,
   input  logic [LDW-1:0]   wdata,
   input  logic [SDW-1:0]   sys_rdata,
   output logic [SDW-1:0]   sys_wdata,
   output logic [LANES-1:0] lane_en,
   output logic [LDW-1:0]   rd_word
);
   generate
      if (LANES == 1) begin : g_narrow
         logic unused_sel;
         assign unused_sel = ^lane_sel;
         assign sys_wdata  = wdata;
         assign lane_en    = 1'b1;
         assign rd_word    = sys_rdata;
      end else begin : g_wide
         for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign sys_wdata[k*LDW +: LDW] = wdata;
            assign lane_en[k] = (lane_sel == LSW'(k));
         end
         always_comb rd_word = sys_rdata[lane_sel*LDW +: LDW];
      end
   endgenerate
endmodule

// File: rtl/lbus_bridge.sv
`timescale 1ns/1ps
// Top: local request port to pipelined system bus master.
module lbus_bridge #(
   parameter int AW  = 32,
   parameter int LDW = 32,
   parameter int SDW = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 loc_req,
   input  logic                 loc_we,
   input  logic                 loc_lock,
   input  logic [AW-1:0]        loc_addr,
   input  logic [LDW-1:0]       loc_wdata,
   output logic                 loc_ack,
   output logic                 loc_rej,
   output logic                 loc_rsp_vld,
   output logic                 loc_rsp_err,
   output logic [LDW-1:0]       loc_rdata,
   output logic                 sys_avld,
   output logic                 sys_dvld,
   output logic [AW-1:0]        sys_addr,
   output logic                 sys_write,
   output logic                 sys_lock,
   output logic [SDW/LDW-1:0]   sys_lane_en,
   output logic [SDW-1:0]       sys_wdata,
   input  logic [SDW-1:0]       sys_rdata,
   input  logic                 sys_rdy,
   input  logic                 sys_err
);
   localparam int LANES = SDW / LDW;
   localparam int LSW   = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int OFS   = $clog2(LDW / 8);

   generate
      if ((LDW % 8) != 0 || LDW < 8) begin : g_bad_ldw
         $error("lbus_bridge: LDW must be a whole number of bytes");
      end
      if ((SDW % LDW) != 0 || (LANES & (LANES - 1)) != 0) begin : g_bad_sdw
         $error("lbus_bridge: SDW must be a power-of-two multiple of LDW");
      end
      if (AW < OFS + LSW) begin : g_bad_aw
         $error("lbus_bridge: AW too small for lane selection");
      end
   endgenerate

   logic           accept, reject, ph_addr, ph_data, fin_ok, fin_err, lock_q;
   logic [AW-1:0]  addr_q;
   logic           we_q;
   logic [LDW-1:0] wdata_q, rd_word;
   logic [SDW-1:0] wdata_rep;
   logic [LANES-1:0] lane_en;
   logic           active;

   lbus_bridge_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .loc_req  (loc_req),
      .loc_lock (loc_lock),
      .sys_rdy  (sys_rdy),
      .sys_err  (sys_err),
      .accept   (accept),
      .reject   (reject),
      .ph_addr  (ph_addr),
      .ph_data  (ph_data),
      .fin_ok   (fin_ok),
      .fin_err  (fin_err),
      .lock_q   (lock_q)
   );

   lbus_bridge_hold #(.AW(AW), .LDW(LDW)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .loc_we    (loc_we),
      .loc_addr  (loc_addr),
      .loc_wdata (loc_wdata),
      .fin_ok    (fin_ok),
      .fin_err   (fin_err),
      .rd_word   (rd_word),
      .addr_q    (addr_q),
      .we_q      (we_q),
      .wdata_q   (wdata_q),
      .rsp_vld   (loc_rsp_vld),
      .rsp_err   (loc_rsp_err),
      .rdata     (loc_rdata)
   );

   lbus_bridge_lanes #(.LDW(LDW), .SDW(SDW), .LANES(LANES), .LSW(LSW)) u_lanes (
      .lane_sel  (addr_q[OFS +: LSW]),
      .wdata     (wdata_q),
      .sys_rdata (sys_rdata),
      .sys_wdata (wdata_rep),
      .lane_en   (lane_en),
      .rd_word   (rd_word)
   );

   assign active      = ph_addr || ph_data;
   assign loc_ack     = accept;
   assign loc_rej     = reject;
   assign sys_avld    = ph_addr;
   assign sys_dvld    = ph_data;
   assign sys_addr    = active ? addr_q : '0;
   assign sys_write   = active && we_q;
   assign sys_lock    = lock_q;
   assign sys_lane_en = active ? lane_en : '0;
   assign sys_wdata   = (ph_data && we_q) ? wdata_rep : '0;
endmodule

// File: rtl/lbus_bridge_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker, bound to the bridge.
module lbus_bridge_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          loc_req,
   input logic          loc_ack,
   input logic          loc_rej,
   input logic          loc_rsp_vld,
   input logic          loc_rsp_err,
   input logic          sys_avld,
   input logic          sys_dvld,
   input logic [AW-1:0] sys_addr,
   input logic          sys_write,
   input logic          sys_lock,
   input logic          sys_rdy,
   input logic          sys_err
);
   p_ack_rej_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_ack && loc_rej));

   p_busy_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      loc_req && (sys_avld || sys_dvld) |-> loc_rej);

   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sys_avld && !sys_rdy && !sys_err |=>
         sys_avld && $stable(sys_addr) && $stable(sys_write));

   p_addr_to_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sys_avld && sys_rdy && !sys_err |=> sys_dvld && !sys_avld);

   // R4 and R5: a response only follows the end of a read
   p_rsp_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      loc_rsp_vld |-> $past((sys_avld || sys_dvld) && !sys_write &&
                            (sys_err || (sys_dvld && sys_rdy))));

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_avld || sys_dvld) && sys_err |=>
         !sys_avld && !sys_dvld && !sys_lock && !sys_write);

   p_release_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_avld || sys_dvld) && sys_err |=> (!loc_req || loc_rej));

   p_err_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      loc_rsp_err |-> loc_rsp_vld);
endmodule

bind lbus_bridge lbus_bridge_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .loc_req     (loc_req),
   .loc_ack     (loc_ack),
   .loc_rej     (loc_rej),
   .loc_rsp_vld (loc_rsp_vld),
   .loc_rsp_err (loc_rsp_err),
   .sys_avld    (sys_avld),
   .sys_dvld    (sys_dvld),
   .sys_addr    (sys_addr),
   .sys_write   (sys_write),
   .sys_lock    (sys_lock),
   .sys_rdy     (sys_rdy),
   .sys_err     (sys_err)
);

// File: tb/lbus_bridge_bench.sv
`timescale 1ns/1ps
module lbus_bridge_bench;
   localparam int AW = 32, LDW = 32, SDW = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic           loc_req = 0, loc_we = 0, loc_lock = 0;
   logic [AW-1:0]  loc_addr = '0;
   logic [LDW-1:0] loc_wdata = '0;
   logic           loc_ack, loc_rej, loc_rsp_vld, loc_rsp_err;
   logic [LDW-1:0] loc_rdata;
   logic           sys_avld, sys_dvld, sys_write, sys_lock;
   logic [AW-1:0]  sys_addr;
   logic [1:0]     sys_lane_en;
   logic [SDW-1:0] sys_wdata;
   logic [SDW-1:0] sys_rdata = '0;
   logic           sys_rdy = 0, sys_err = 0;

   int  n_tests = 0, n_fail = 0;
   bit  exp_lock = 0;
   bit  done = 0;

   lbus_bridge #(.AW(AW), .LDW(LDW), .SDW(SDW)) u_lbus_bridge (.*);

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Starts at negedge+1; returns at negedge+1 of the first cycle a new request may be accepted.
   task automatic run(input bit we, input bit lk, input logic [31:0] addr,
                      input logic [31:0] wd, input int aw, input int dw, input int eph);
      logic [31:0] w0, w1, ew;
      bit lane;
      lane = addr[2];
      w0 = addr ^ 32'hA5A5_0000;
      w1 = addr ^ 32'h5A5A_FFFF;
      ew = lane ? w1 : w0;
      loc_req = 1; loc_we = we; loc_lock = lk; loc_addr = addr; loc_wdata = wd;
      sys_rdy = 0; sys_err = 0;
      #1;
      check("R1 ack when idle", loc_ack, 1);
      check("R2 no reject when idle", loc_rej, 0);
      exp_lock = lk;
      for (int i = 0; i <= aw; i++) begin
         @(negedge clk);
         loc_req = (i == 0); loc_we = ~we; loc_lock = ~lk; loc_addr = addr ^ 32'h100;
         sys_rdy = (i == aw) && (eph != 1);
         sys_err = (i == aw) && (eph == 1);
         #1;
         check("R3 addr phase valid", sys_avld, 1);
         check("R3 no data phase yet", sys_dvld, 0);
         check("R1 captured address", sys_addr, addr);
         check("R1 captured direction", sys_write, we);
         check("R8 lock in addr phase", sys_lock, exp_lock);
         check("R10 lane enable addr", sys_lane_en, lane ? 2'b10 : 2'b01);
         if (i == 0) begin
            check("R2 reject while busy", loc_rej, 1);
            check("R2 no ack while busy", loc_ack, 0);
            check("R4 response one cycle", loc_rsp_vld, 0);
         end
      end
      if (eph != 1) begin
         for (int j = 0; j <= dw; j++) begin
            @(negedge clk);
            loc_req = 0;
            sys_rdy = (j == dw) && (eph != 2);
            sys_err = (j == dw) && (eph == 2);
            sys_rdata = (j == dw) ? {w1, w0} : ~{w1, w0};
            #1;
            check("R3 data phase valid", sys_dvld, 1);
            check("R3 addr phase ended", sys_avld, 0);
            check("R10 lane enable data", sys_lane_en, lane ? 2'b10 : 2'b01);
            check("R8 lock in data phase", sys_lock, exp_lock);
            check("R4 no early response", loc_rsp_vld, 0);
            if (we) check("R5 write data replicated", sys_wdata, {wd, wd});
         end
      end
      @(negedge clk);
      loc_req = (eph != 0); loc_we = 0; loc_lock = 0;
      sys_rdy = 0; sys_err = 0;
      #1;
      if (eph != 0) begin
         exp_lock = 0;
         check("R6 release avld", sys_avld, 0);
         check("R6 release dvld", sys_dvld, 0);
         check("R6 release write", sys_write, 0);
         check("R6 release lock", sys_lock, 0);
         check("R6 reject in release", loc_rej, 1);
         check("R6 no ack in release", loc_ack, 0);
         if (we) check("R5 no write error response", loc_rsp_vld, 0);
         else begin
            check("R7 error response valid", loc_rsp_vld, 1);
            check("R7 error flag", loc_rsp_err, 1);
            check("R7 error data zero", loc_rdata, 0);
         end
         @(negedge clk);
         loc_req = 0;
         #1;
         check("R6 lock stays low", sys_lock, 0);
         check("R6 no retry", sys_avld, 0);
      end else begin
         check("R2 refused request not queued", sys_avld, 0);
         check("R3 data phase ended", sys_dvld, 0);
         check("R8 lock held in idle", sys_lock, exp_lock);
         if (we) check("R5 no write response", loc_rsp_vld, 0);
         else begin
            check("R4 read response valid", loc_rsp_vld, 1);
            check("R4 read no error", loc_rsp_err, 0);
            check("R10 read lane data", loc_rdata, ew);
         end
      end
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      #1;
      check("R9 reset avld", sys_avld, 0);
      check("R9 reset dvld", sys_dvld, 0);
      check("R9 reset lock", sys_lock, 0);
      check("R9 reset write", sys_write, 0);
      check("R9 reset rsp", loc_rsp_vld, 0);
      @(negedge clk);
      rst_n = 1;
      #1;
      for (int idx = 0; idx < 108; idx++) begin
         int ln, we, aw, dw, eph;
         eph = idx % 3;
         dw  = (idx / 3) % 3;
         aw  = (idx / 9) % 3;
         we  = (idx / 27) % 2;
         ln  = (idx / 54) % 2;
         run(we[0], 1'b0, 32'h8000_0000 + (idx << 3) + (ln << 2),
             32'hC0DE_0000 + idx, aw, dw, eph);
      end
      // lock sequences
      run(1'b0, 1'b1, 32'h8000_1000, 32'h0, 0, 1, 0);
      check("R8 locked idle", sys_lock, 1);
      run(1'b1, 1'b0, 32'h8000_1004, 32'h1234_5678, 1, 0, 0);
      check("R8 unlocked after plain access", sys_lock, 0);
      run(1'b0, 1'b1, 32'h8000_1008, 32'h0, 0, 2, 2);
      run(1'b1, 1'b1, 32'h8000_100C, 32'hFEED_BEEF, 2, 0, 1);
      run(1'b0, 1'b0, 32'h8000_1010, 32'h0, 0, 0, 0);
      // reset during a locked transfer
      loc_req = 1; loc_we = 0; loc_lock = 1; loc_addr = 32'h8000_2000;
      @(negedge clk);
      loc_req = 0;
      #1;
      check("R8 lock set by request", sys_lock, 1);
      rst_n = 0;
      @(negedge clk);
      #1;
      check("R9 reset clears lock", sys_lock, 0);
      check("R9 reset clears phase", sys_avld, 0);
      rst_n = 1;
      @(negedge clk);
      #1;
      check("R9 idle after reset", sys_dvld, 0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule